// File: doc/BRIEF.md
# Self-Framing Serial Segment Display Driver

This block receives display data over a two-wire serial link and drives static LCD segment outputs with a backplane square wave. Software or a controller shifts a frame made of one start bit ('1') followed by the segment bits. The frame is sent most significant segment first. No load strobe or chip select is used. The block waits for the first '1' while idle, counts serial clocks from that start bit, and copies the shift register into the output latches when the 36th clock of the frame has completed. The latched word then stays in place until the next complete frame arrives.

The serial clock, data and enable inputs are treated as slow asynchronous signals. Each is synchronized into the system clock domain, and data is sampled on each rising edge of the serial clock. A parameter selects between two variants. The default variant has 32 segments and an active-low enable that gates reception. The other variant ignores the enable pin and takes a 33rd segment bit. The backplane is a 50% duty square wave made by dividing the system clock. Each segment output is its latched bit XOR the backplane, so a lit segment is driven in antiphase and an unlit one in phase.

Top module: `serial_seg_driver`

## Requirements
- R1: While idle, serial clocks carrying '0' are ignored; the first '1' sampled while idle is taken as the start bit of a frame.
- R2: The NSEG bits that follow the start bit are shifted in, and the first one received ends up in the highest segment index (seg[NSEG-1]).
- R3: The latches load once the 36th rising serial clock edge of the frame (start bit counted as the 1st) has been seen; after only 35 edges the outputs still show the previous word.
- R4: The latched word is held unchanged between frames, and resending the same word causes no change on any segment output.
- R5: In the enable variant (EXTRA_SEG=0), while en_n is high the receiver is forced idle and serial clocks are ignored; a frame interrupted this way is discarded, the outputs keep the previous word, and after en_n returns low the next '1' starts a fresh frame.
- R6: In the 33-segment variant (EXTRA_SEG=1), en_n has no effect and a 33rd data bit is received and driven, so the same 36-clock frame loads {32 data bits, extra bit} with the extra bit on seg[0].
- R7: bp is a square wave that toggles every BP_HALF system clock cycles, starting low after reset.
- R8: Every segment output equals its latched bit XOR bp, so a '1' segment is the inverse of bp and a '0' segment equals bp.
- R9: Synchronous reset clears the latches, the receiver and the divider, so after reset bp is low and every segment output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| sdata | input | 1 | Serial data |
| en_n | input | 1 | Active-low receive enable (unused when EXTRA_SEG=1) |
| seg | output | NSEG | Segment drive outputs (32 or 33) |
| bp | output | 1 | Backplane square wave |

## Verification
The assertions check on every cycle that a frame only starts on a sampled '1', that the receiver only returns to idle at the latch count or when disabled, that the latches move only on a load, that a disabled receiver sits idle, and that bp toggles only at the divider wrap. Whether the loaded word carries the right bits in the right order, the exact edge count before loading, alignment after leading zeros, discarding of an interrupted frame, and the phase of each segment against bp can only be shown by the bench's frames, which decode the outputs against bp and compare them with the sent words.

// File: rtl/serial_seg_driver.sv
module serial_seg_driver #(
  parameter bit EXTRA_SEG = 1'b0,
  parameter int BP_HALF   = 64,
  parameter int LATCH_CNT = 36,
  localparam int NSEG = 32 + int'(EXTRA_SEG),
  localparam int DW   = (BP_HALF > 2) ? $clog2(BP_HALF) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            sdata,
  input  logic            en_n,
  output logic [NSEG-1:0] seg,
  output logic            bp
);

  logic [2:0]      sclk_q;
  logic [1:0]      sd_q;
  logic [1:0]      en_q;
  logic            rise, sd_s, gate, load;
  logic            busy;
  logic [5:0]      cnt;
  logic [NSEG-1:0] shreg, lat;
  logic [DW-1:0]   div;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      sd_q   <= '0;
      en_q   <= '1;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sd_q   <= {sd_q[0], sdata};
      en_q   <= {en_q[0], en_n};
    end
  end

  assign rise = sclk_q[1] & ~sclk_q[2];
  assign sd_s = sd_q[1];
  assign gate = !EXTRA_SEG && en_q[1];
  assign load = !gate && rise && busy && (cnt == 6'(LATCH_CNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (gate) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (rise) begin
      if (!busy) begin
        if (sd_s) begin
          busy <= 1'b1;
          cnt  <= 6'd1;
        end
      end else if (load) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 6'd1;
        if (cnt <= 6'(NSEG)) shreg <= {shreg[NSEG-2:0], sd_s};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       lat <= '0;
    else if (load) lat <= shreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0;
      bp  <= 1'b0;
    end else if (div == DW'(BP_HALF - 1)) begin
      div <= '0;
      bp  <= ~bp;
    end else begin
      div <= div + 1'b1;
    end
  end

  assign seg = lat ^ {NSEG{bp}};

  a_r1_start_on_one: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sd_s) && $past(rise));

  a_r3_idle_at_count: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(gate) || ($past(cnt) == 6'(LATCH_CNT - 1)));

  a_r4_hold_latch: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lat));

  a_r5_gate_idle: assert property (@(posedge clk) disable iff (rst)
    gate |=> !busy && (cnt == 6'd0));

  a_r7_bp_toggle: assert property (@(posedge clk) disable iff (rst)
    (bp != $past(bp)) |-> ($past(div) == DW'(BP_HALF - 1)));

endmodule

// File: tb/serial_seg_driver_test.sv
module serial_seg_driver_test;
  localparam int BPH = 64;

  logic clk = 0, rst = 1, sclk = 0, sdata = 0, en_n = 0;
  logic [31:0] seg;
  logic [32:0] seg33;
  logic bp, bp33;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  serial_seg_driver #(.EXTRA_SEG(1'b0), .BP_HALF(BPH)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .en_n(en_n), .seg(seg), .bp(bp));
  serial_seg_driver #(.EXTRA_SEG(1'b1), .BP_HALF(BPH)) uut33 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .en_n(en_n), .seg(seg33), .bp(bp33));

  // {lead zeros[3:0], 32 data bits, extra bit}
  localparam logic [36:0] VEC [8] = '{
    {4'd0, 32'hDEADBEEF, 1'b1}, {4'd3, 32'h00000001, 1'b0},
    {4'd0, 32'hFFFFFFFF, 1'b1}, {4'd7, 32'h80000000, 1'b0},
    {4'd1, 32'hA5A55A5A, 1'b1}, {4'd0, 32'h00000000, 1'b0},
    {4'd15, 32'h12345678, 1'b1}, {4'd2, 32'hC3C33C3C, 1'b0}};

  function automatic logic [31:0] word32();
    return seg ^ {32{bp}};
  endfunction
  function automatic logic [32:0] word33();
    return seg33 ^ {33{bp33}};
  endfunction

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdata = b; waitn(5);
    sclk = 1;  waitn(10);
    sclk = 0;  waitn(5);
  endtask

  task automatic send_bits(input logic [32:0] d, input int n);
    for (int i = 32; i > 32 - n; i--) pulse(d[i]);
  endtask

  task automatic frame(input int lead, input logic [32:0] d);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    pulse(1'b1);
    send_bits(d, 33);
    pulse(1'b0);
    pulse(1'b0);
  endtask

  logic mon_en = 0, mon_bad = 0;
  logic [31:0] mon_word;
  always @(negedge clk)
    if (mon_en && word32() !== mon_word) mon_bad = 1;

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] prev;
    int t;
    waitn(4);
    rst = 0;
    @(negedge clk);
    chk("R9 reset bp", {32'd0, bp}, 33'd0);
    chk("R9 reset seg", {1'b0, seg}, 33'd0);
    chk("R9 reset seg33", seg33, 33'd0);

    // R7: measure bp half period
    while (bp == 1'b0) @(negedge clk);
    t = 0;
    while (bp == 1'b1) begin @(negedge clk); t++; end
    chk("R7 bp half period", 33'(t), 33'(BPH));

    foreach (VEC[k]) begin
      frame(int'(VEC[k][36:33]), VEC[k][32:0]);
      chk("R1 R2 word after frame", {1'b0, word32()}, {1'b0, VEC[k][32:1]});
      chk("R6 33-seg word", word33(), VEC[k][32:0]);
    end

    // R8: phase of every segment against bp, both bp levels
    prev = {1'b0, word32()};
    while (bp == 1'b0) @(negedge clk);
    chk("R8 seg when bp high", {1'b0, seg}, {1'b0, ~prev[31:0]});
    while (bp == 1'b1) @(negedge clk);
    chk("R8 seg when bp low", {1'b0, seg}, prev);

    // R3: 35 edges leave old word, 36th loads
    prev = {1'b0, word32()};
    pulse(1'b1);
    send_bits({32'h0F0F1234, 1'b1}, 33);
    pulse(1'b0);
    chk("R3 unchanged after 35 edges", {1'b0, word32()}, prev);
    pulse(1'b0);
    chk("R3 loaded after 36th edge", {1'b0, word32()}, {1'b0, 32'h0F0F1234});

    // R4: hold while idle, and resend of same word causes no change
    waitn(300);
    chk("R4 held while idle", {1'b0, word32()}, {1'b0, 32'h0F0F1234});
    mon_word = 32'h0F0F1234; mon_bad = 0; mon_en = 1;
    frame(0, {32'h0F0F1234, 1'b0});
    mon_en = 0;
    chk("R4 no change on resend", {32'd0, mon_bad}, 33'd0);

    // R5: enable deasserted partway through
    prev = {1'b0, word32()};
    pulse(1'b1);
    send_bits({32'hFFFF0000, 1'b0}, 9);
    en_n = 1; waitn(5);
    for (int i = 0; i < 26; i++) pulse(i[0]);
    chk("R5 partial frame discarded", {1'b0, word32()}, prev);
    en_n = 0; waitn(5);
    frame(2, {32'h5A5A00FF, 1'b1});
    chk("R5 fresh frame after enable", {1'b0, word32()}, {1'b0, 32'h5A5A00FF});
    chk("R6 enable ignored, 33-seg word", word33(), {32'h5A5A00FF, 1'b1});

    // R5: full frame while disabled is ignored; R6 variant still receives
    en_n = 1; waitn(5);
    frame(0, {32'h11112222, 1'b0});
    chk("R5 frame ignored while disabled", {1'b0, word32()}, {1'b0, 32'h5A5A00FF});
    chk("R6 receives while en_n high", word33(), {32'h11112222, 1'b0});
    en_n = 0; waitn(5);

    // R9: reset mid-operation
    rst = 1; waitn(2); rst = 0; @(negedge clk);
    chk("R9 reset clears seg", {1'b0, seg}, 33'd0);
    chk("R9 reset clears seg33", seg33, 33'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule